// File: doc/BRIEF.md
# Transition-Driven Pre-Emphasis Controller

This block sits just ahead of the output drivers of a multi-lane serial transmitter. On every clock it accepts one serialized bit for each lane. For each lane it returns that bit, delayed by one register, together with a boost flag that tells the lane's driver to add extra current for that bit period. The flag is raised only when the bit differs from the bit sent just before it on the same lane. When the bit repeats, the flag drops and the driver falls back to its normal current. This sharpens edges without over-driving long runs.

One emphasis enable governs every lane. A separate swing-select input asks the drivers for either the normal or the doubled output swing, and it works regardless of the emphasis setting. Both configuration inputs may change asynchronously to the bit clock. Each of them therefore passes through a synchronizer of `SYNC_STAGES` flops (default 2) before it can reach the outputs. Current values, resistor sensing and the analog driver are outside this block.

Top module: `preemph_ctrl`

## Requirements
- R1: For every lane, `dataOut` equals the `bitIn` value sampled at the previous rising clock edge (one cycle of latency).
- R2: With emphasis active, `boostOut` for a lane is 1 in exactly the cycle in which that lane's `dataOut` holds a bit that differs from the bit it held in the cycle before.
- R3: When a lane's bit repeats its previous value, that lane's `boostOut` is 0 for the repeated bit. A long run therefore gets one boosted bit followed by normal bits.
- R4: While the synchronized emphasis enable is 0, `boostOut` is 0 on every lane, whatever the data.
- R5: All lanes share the single enable, and each lane's boost depends only on its own bit history. Lanes that toggle differently get different boost patterns in the same cycle.
- R6: While `rstN` is low, `dataOut`, `boostOut` and `levelOut` are all 0. Every lane's previous bit is taken as 0, so a first bit of 1 after reset counts as a transition and a first bit of 0 does not.
- R7: `levelOut` is 0 (normal swing) when `ampSel` is low and 1 (double swing) when it is high. It follows `ampSel` whether emphasis is enabled or not.
- R8: Suppose `emphEn` or `ampSel` changes before rising edge k and then holds. With default `SYNC_STAGES`=2, `boostOut` and `levelOut` first reflect the new value after edge k+2; after edges k and k+1 they still act on the old value.
- R9: The lane count is the parameter `NUM_LANES`, default 2, and the synchronizer depth is the parameter `SYNC_STAGES` (at least 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| emphEn | input | 1 | Global emphasis enable, asynchronous |
| ampSel | input | 1 | Swing select: 0 normal, 1 double; asynchronous |
| bitIn | input | NUM_LANES | One serialized bit per lane, bit i is lane i |
| dataOut | output | NUM_LANES | Bits delayed one cycle, aligned with `boostOut` |
| boostOut | output | NUM_LANES | Per-lane boost flag for the current output bit |
| levelOut | output | 1 | Registered swing code: 0 normal, 1 double |

## Verification
Several data patterns are applied. An alternating pattern must boost every bit. Long runs must boost only the first bit of each run, which separates a transition detector from a level detector. Lanes driven in opposite or unrelated ways show that each lane keeps its own history. Toggling data with emphasis off shows that the enable gates every lane. Changing the enable and the swing select in the middle of traffic checks the synchronizer latency of R8, and toggling the swing select while emphasis is off shows that the two controls are independent. A pseudo-random stream then covers mixed runs.

// File: rtl/pe_pkg.sv
package pe_pkg;
  // Strobes from the control path to the lane datapath
  typedef struct packed {
    logic boostEn;  // synchronized emphasis enable
    logic ampHigh;  // synchronized swing select
  } peStrobe_t;
endpackage

// File: rtl/pe_ctrl.sv
module pe_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              emphEn,
  input  logic              ampSel,
  output pe_pkg::peStrobe_t strobe
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] enChain;
  logic [MSB:0] ampChain;

  // Synchronizer chains for the asynchronous configuration inputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enChain  <= '0;
      ampChain <= '0;
    end else begin
      enChain  <= {enChain[MSB-1:0], emphEn};
      ampChain <= {ampChain[MSB-1:0], ampSel};
    end
  end

  always_comb begin
    strobe.boostEn = enChain[MSB];
    strobe.ampHigh = ampChain[MSB];
  end

  initial begin
    assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES below 2 (R9)");
  end
endmodule

// File: rtl/pe_datapath.sv
module pe_datapath #(
  parameter int NUM_LANES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pe_pkg::peStrobe_t    strobe,
  input  logic [NUM_LANES-1:0] bitIn,
  output logic [NUM_LANES-1:0] dataOut,
  output logic [NUM_LANES-1:0] boostOut,
  output logic                 levelOut
);
  logic [NUM_LANES-1:0] dataQ;
  logic [NUM_LANES-1:0] boostQ;
  logic                 levelQ;
  logic                 pastValid;

  // Per-lane bit delay and transition boost; dataQ doubles as the previous bit
  for (genvar lane = 0; lane < NUM_LANES; lane++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataQ[lane]  <= 1'b0;
        boostQ[lane] <= 1'b0;
      end else begin
        dataQ[lane]  <= bitIn[lane];
        boostQ[lane] <= strobe.boostEn & (bitIn[lane] ^ dataQ[lane]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ    <= 1'b0;
      pastValid <= 1'b0;
    end else begin
      levelQ    <= strobe.ampHigh;
      pastValid <= 1'b1;
    end
  end

  assign dataOut  = dataQ;
  assign boostOut = boostQ;
  assign levelOut = levelQ;

  // R1: output bit is the input bit one edge earlier
  assert_data_delay_R1: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> dataOut == $past(bitIn));

  // R2: with emphasis on, boost marks exactly the lanes whose output bit changed
  assert_change_boost_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(strobe.boostEn)) |-> boostOut == (dataOut ^ $past(dataOut)));

  // R3: a repeated bit never carries boost
  assert_repeat_no_boost_R3: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (boostOut & ~(dataOut ^ $past(dataOut))) == '0);

  // R4: enable off silences boost on all lanes
  assert_gate_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(strobe.boostEn)) |-> boostOut == '0);

  // R7: swing code follows the synchronized select one edge later
  assert_level_follow_R7: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> levelOut == $past(strobe.ampHigh));
endmodule

// File: rtl/preemph_ctrl.sv
module preemph_ctrl #(
  parameter int NUM_LANES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 emphEn,
  input  logic                 ampSel,
  input  logic [NUM_LANES-1:0] bitIn,
  output logic [NUM_LANES-1:0] dataOut,
  output logic [NUM_LANES-1:0] boostOut,
  output logic                 levelOut
);
  pe_pkg::peStrobe_t strobe;

  pe_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .emphEn (emphEn),
    .ampSel (ampSel),
    .strobe (strobe)
  );

  pe_datapath #(.NUM_LANES(NUM_LANES)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .bitIn    (bitIn),
    .dataOut  (dataOut),
    .boostOut (boostOut),
    .levelOut (levelOut)
  );
endmodule

// File: tb/preemph_ctrl_bench.sv
`timescale 1ns/1ps
module preemph_ctrl_bench;
  localparam int LANES = 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             emphEn = 1'b0;
  logic             ampSel = 1'b0;
  logic [LANES-1:0] bitIn = '0;
  logic [LANES-1:0] dataOut;
  logic [LANES-1:0] boostOut;
  logic             levelOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  preemph_ctrl #(.NUM_LANES(LANES)) u_preemph_ctrl (
    .clk(clk), .rstN(rstN), .emphEn(emphEn), .ampSel(ampSel),
    .bitIn(bitIn), .dataOut(dataOut), .boostOut(boostOut), .levelOut(levelOut)
  );

  typedef struct {
    logic [LANES-1:0] d;
    logic [LANES-1:0] b;
    logic             lv;
    string            tag;
  } expItem_t;

  expItem_t expQ[$];

  // Bench model of the requirements: one-cycle bit delay, two-stage config sync
  logic [LANES-1:0] mPrev = '0;
  logic mEn1 = 0, mEn2 = 0, mAmp1 = 0, mAmp2 = 0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [LANES-1:0] b, logic en, logic amp, string tag);
    expItem_t it;
    @(negedge clk);
    bitIn = b; emphEn = en; ampSel = amp;
    it.d   = b;
    it.b   = mEn2 ? (b ^ mPrev) : '0;
    it.lv  = mAmp2;
    it.tag = tag;
    expQ.push_back(it);
    mPrev = b;
    mEn2 = mEn1; mEn1 = en;
    mAmp2 = mAmp1; mAmp1 = amp;
  endtask

  // Monitor: compare after each edge that has a pending expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check("R1", "dataOut", 32'(dataOut), 32'(it.d));
        check(it.tag, "boostOut", 32'(boostOut), 32'(it.b));
        check("R7", "levelOut", 32'(levelOut), 32'(it.lv));
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [6:0] lfsr;
    // R6: reset state, with data and config pushed high during reset
    bitIn = '1; emphEn = 1; ampSel = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6", "dataOut in reset", 32'(dataOut), 0);
    check("R6", "boostOut in reset", 32'(boostOut), 0);
    check("R6", "levelOut in reset", 32'(levelOut), 0);
    bitIn = '0; emphEn = 0; ampSel = 0;
    rstN = 1;
    // R6: first bit 1 after reset counts as a transition from 0
    repeat (3) drive(2'b00, 1, 0, "R6");
    drive(2'b01, 1, 0, "R6");
    // R2: alternating data boosts every bit
    for (int i = 0; i < 8; i++) drive(i[0] ? 2'b11 : 2'b00, 1, 0, "R2");
    // R3: long runs boost only their first bit
    repeat (6) drive(2'b11, 1, 0, "R3");
    repeat (6) drive(2'b00, 1, 0, "R3");
    // R5: lanes toggle independently under the shared enable
    for (int i = 0; i < 8; i++) drive({1'b0, i[0]} ^ {i[1], 1'b0}, 1, 0, "R5");
    drive(2'b01, 1, 0, "R5");
    drive(2'b10, 1, 0, "R5");
    // R8 and R4: drop enable mid-stream; boost persists two more edges, then stops
    for (int i = 0; i < 8; i++) drive(i[0] ? 2'b10 : 2'b01, 0, 0, "R8");
    for (int i = 0; i < 8; i++) drive(i[0] ? 2'b11 : 2'b00, 0, 0, "R4");
    // R7 with R4: swing select toggles while emphasis is off
    for (int i = 0; i < 6; i++) drive(i[0] ? 2'b01 : 2'b10, 0, i[1], "R4");
    // R8: raise enable and swing select together during toggling data
    for (int i = 0; i < 6; i++) drive(i[0] ? 2'b11 : 2'b00, 1, 1, "R8");
    // R2/R3: pseudo-random mixed runs
    lfsr = 7'h5b;
    for (int i = 0; i < 80; i++) begin
      lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
      drive(lfsr[1:0], 1, lfsr[4] & lfsr[2], "R2");
    end
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule